// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Decoder

This block sits after instruction fetch and turns a stream of 16-bit parcels into whole instructions. Every instruction starts with a base parcel that holds an 8-bit opcode and two 4-bit register fields. Depending on the opcode, zero, one or two extension parcels follow and carry an immediate operand. The decoder collects the parcels one at a time through a valid/ready handshake. When the final parcel of an instruction is accepted, it emits one decoded record in that same cycle, with the 32-bit operand already widened.

Parameter tables choose which opcodes take a 16-bit immediate (one extension parcel), which take a 32-bit immediate (two extension parcels), and which are short-immediate forms. In a short-immediate form the 4-bit source field is itself the operand. For one group of these, the operand is the complement of the value. Any opcode not listed in a table is a one-parcel instruction. A synchronous flush drops a partly assembled instruction, for example after a branch redirect.

Top module: `parcel_decoder`

## Requirements
- R1: For every emitted instruction, the record reports base-parcel bits 15:8 as the opcode, bits 7:4 as the source register and bits 3:0 as the destination register.
- R2: An opcode found in none of the tables completes in the cycle its base parcel is accepted, with has_imm 0, an operand of zero and length 1.
- R3: An opcode in the 16-bit immediate table takes exactly one extension parcel. It completes when that parcel is accepted, with length 2, has_imm 1 and the parcel sign-extended to 32 bits.
- R4: An opcode in the 32-bit immediate table takes exactly two extension parcels. The first supplies operand bits 15:0 and the second supplies bits 31:16. It completes on the second, with length 3 and has_imm 1.
- R5: An opcode in the short-immediate table completes in one parcel, with has_imm 1 and the operand equal to the zero-extended 4-bit source field.
- R6: An opcode in the complemented short-immediate table completes in one parcel, with has_imm 1 and the operand equal to the bitwise NOT of the zero-extended 4-bit source field.
- R7: While flush is high, in_ready is low and no record is emitted. The partial instruction is dropped, and the next accepted parcel is treated as a base parcel.
- R8: out_valid is high only in a cycle where a parcel is accepted (in_valid and in_ready both high) and that parcel ends an instruction. Cycles with in_valid low leave the assembly state unchanged. After reset, the decoder expects a base parcel, with in_ready 1 and out_valid 0.
- R9: When an opcode appears in more than one table, the 32-bit immediate table wins over the 16-bit table. The 16-bit table wins over the complemented short table, and that wins over the plain short table.
- R10: out_rec is 51 bits wide. Its fields are: opcode [50:43], source register [42:39], destination register [38:35], operand [34:3], has_imm [2], and length [1:0] (1, 2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of a partly assembled instruction |
| in_valid | input | 1 | Parcel present |
| in_parcel | input | 16 | Instruction parcel |
| in_ready | output | 1 | Decoder accepts a parcel this cycle |
| out_valid | output | 1 | One-cycle pulse: a record is complete |
| out_rec | output | 51 | Decoded instruction record |

## Verification
The bench builds the decoder with three entries in each immediate table, and places opcode 0x95 in both the 16-bit and the 32-bit table. This makes the table-priority rule observable at the ports. The default short-immediate tables are kept: three zero-extended opcodes and one complemented opcode. Directed sequences first cover each instruction form, negative and positive 16-bit operands, idle gaps between parcels, and flushes in each extension state. A pseudo-random stream of opcodes, gaps and flushes then follows, compared cycle by cycle against a behavioural model that keeps a queue of parcels.

// File: rtl/parcel_dec_pkg.sv
package parcel_dec_pkg;
   localparam int PARCEL_W = 16;
   localparam int OP_W     = 8;
   localparam int REG_W    = 4;
   localparam int IMM_W    = 32;
   localparam int LEN_W    = 2;

   typedef enum logic [1:0] {
      ST_BASE = 2'd0,
      ST_EXT1 = 2'd1,
      ST_EXT2 = 2'd2
   } pd_state_e;

   typedef enum logic [2:0] {
      K_PLAIN = 3'd0,
      K_QUICK = 3'd1,
      K_QNOT  = 3'd2,
      K_IMM16 = 3'd3,
      K_IMM32 = 3'd4
   } pd_kind_e;

   typedef struct packed {
      logic [OP_W-1:0]  opcode;
      logic [REG_W-1:0] rs;
      logic [REG_W-1:0] rd;
      logic [IMM_W-1:0] imm32;
      logic             has_imm;
      logic [LEN_W-1:0] plen;
   } pd_rec_t;

   localparam int REC_W = $bits(pd_rec_t);
endpackage

// File: rtl/parcel_op_classify.sv
module parcel_op_classify
   import parcel_dec_pkg::*;
#(
   parameter int N_IMM16 = 2,
   parameter int N_IMM32 = 2,
   parameter int N_QUICK = 3,
   parameter int N_QNOT  = 1,
   parameter logic [N_IMM16*OP_W-1:0] IMM16_OPS = {8'h83, 8'h93},
   parameter logic [N_IMM32*OP_W-1:0] IMM32_OPS = {8'h84, 8'h94},
   parameter logic [N_QUICK*OP_W-1:0] QUICK_OPS = {8'h82, 8'h8A, 8'h8C},
   parameter logic [N_QNOT*OP_W-1:0]  QNOT_OPS  = {8'h8E}
) (
   input  logic [OP_W-1:0] op,
   output pd_kind_e        kind
);
   if (N_IMM16 < 1 || N_IMM32 < 1 || N_QUICK < 1 || N_QNOT < 1) begin : g_bad_tables
      $error("parcel_op_classify: every opcode table needs at least one entry");
   end

   logic [N_IMM16-1:0] hit16;
   logic [N_IMM32-1:0] hit32;
   logic [N_QUICK-1:0] hitq;
   logic [N_QNOT-1:0]  hitqn;

   for (genvar i = 0; i < N_IMM16; i++) begin : g_h16
      assign hit16[i] = (op == IMM16_OPS[i*OP_W +: OP_W]);
   end
   for (genvar i = 0; i < N_IMM32; i++) begin : g_h32
      assign hit32[i] = (op == IMM32_OPS[i*OP_W +: OP_W]);
   end
   for (genvar i = 0; i < N_QUICK; i++) begin : g_hq
      assign hitq[i] = (op == QUICK_OPS[i*OP_W +: OP_W]);
   end
   for (genvar i = 0; i < N_QNOT; i++) begin : g_hqn
      assign hitqn[i] = (op == QNOT_OPS[i*OP_W +: OP_W]);
   end

   always_comb begin
      if (|hit32)      kind = K_IMM32;
      else if (|hit16) kind = K_IMM16;
      else if (|hitqn) kind = K_QNOT;
      else if (|hitq)  kind = K_QUICK;
      else             kind = K_PLAIN;
   end
endmodule

// File: rtl/parcel_imm_build.sv
module parcel_imm_build
   import parcel_dec_pkg::*;
(
   input  pd_kind_e             kind,
   input  logic [REG_W-1:0]     qfield,
   input  logic [PARCEL_W-1:0]  lo_half,
   input  logic [PARCEL_W-1:0]  cur,
   output logic [IMM_W-1:0]     imm
);
   localparam int QPAD = IMM_W - REG_W;
   localparam int SPAD = IMM_W - PARCEL_W;

   logic [IMM_W-1:0] qzext;
   assign qzext = {{QPAD{1'b0}}, qfield};

   always_comb begin
      unique case (kind)
         K_QUICK: imm = qzext;
         K_QNOT:  imm = ~qzext;
         K_IMM16: imm = {{SPAD{cur[PARCEL_W-1]}}, cur};
         K_IMM32: imm = {cur, lo_half};
         default: imm = '0;
      endcase
   end
endmodule

// File: rtl/parcel_decoder.sv
module parcel_decoder
   import parcel_dec_pkg::*;
#(
   parameter int N_IMM16 = 2,
   parameter int N_IMM32 = 2,
   parameter int N_QUICK = 3,
   parameter int N_QNOT  = 1,
   parameter logic [N_IMM16*8-1:0] IMM16_OPS = {8'h83, 8'h93},
   parameter logic [N_IMM32*8-1:0] IMM32_OPS = {8'h84, 8'h94},
   parameter logic [N_QUICK*8-1:0] QUICK_OPS = {8'h82, 8'h8A, 8'h8C},
   parameter logic [N_QNOT*8-1:0]  QNOT_OPS  = {8'h8E}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush,
   input  logic        in_valid,
   input  logic [15:0] in_parcel,
   output logic        in_ready,
   output logic        out_valid,
   output logic [50:0] out_rec
);
   pd_state_e           st_q;
   pd_kind_e            kind_q, kind_new, kind_cur;
   logic [PARCEL_W-1:0] base_q, lo_q, base_cur;
   logic                accept, last;
   logic [IMM_W-1:0]    imm;
   pd_rec_t             rec;

   parcel_op_classify #(
      .N_IMM16(N_IMM16), .N_IMM32(N_IMM32), .N_QUICK(N_QUICK), .N_QNOT(N_QNOT),
      .IMM16_OPS(IMM16_OPS), .IMM32_OPS(IMM32_OPS),
      .QUICK_OPS(QUICK_OPS), .QNOT_OPS(QNOT_OPS)
   ) u_class (
      .op   (in_parcel[15:8]),
      .kind (kind_new)
   );

   assign in_ready = !flush;
   assign accept   = in_valid && in_ready;
   assign base_cur = (st_q == ST_BASE) ? in_parcel : base_q;
   assign kind_cur = (st_q == ST_BASE) ? kind_new  : kind_q;

   always_comb begin
      unique case (st_q)
         ST_BASE: last = (kind_cur == K_PLAIN) || (kind_cur == K_QUICK) || (kind_cur == K_QNOT);
         ST_EXT1: last = (kind_cur == K_IMM16);
         default: last = 1'b1;
      endcase
   end

   parcel_imm_build u_imm (
      .kind    (kind_cur),
      .qfield  (base_cur[7:4]),
      .lo_half (lo_q),
      .cur     (in_parcel),
      .imm     (imm)
   );

   always_comb begin
      rec.opcode  = base_cur[15:8];
      rec.rs      = base_cur[7:4];
      rec.rd      = base_cur[3:0];
      rec.imm32   = imm;
      rec.has_imm = (kind_cur != K_PLAIN);
      unique case (st_q)
         ST_BASE: rec.plen = 2'd1;
         ST_EXT1: rec.plen = 2'd2;
         default: rec.plen = 2'd3;
      endcase
   end

   assign out_valid = accept && last;
   assign out_rec   = rec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BASE;
         kind_q <= K_PLAIN;
         base_q <= '0;
         lo_q   <= '0;
      end else if (flush) begin
         st_q <= ST_BASE;
      end else if (accept) begin
         unique case (st_q)
            ST_BASE: begin
               if (!last) begin
                  st_q   <= ST_EXT1;
                  base_q <= in_parcel;
                  kind_q <= kind_new;
               end
            end
            ST_EXT1: begin
               if (last) st_q <= ST_BASE;
               else begin
                  st_q <= ST_EXT2;
                  lo_q <= in_parcel;
               end
            end
            default: st_q <= ST_BASE;
         endcase
      end
   end
endmodule

// File: rtl/parcel_decoder_chk.sv
module parcel_decoder_chk
   import parcel_dec_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        flush,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic [50:0] out_rec,
   input logic [1:0]  st
);
   pd_rec_t r;
   assign r = out_rec;

   assert_accept_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_valid && in_ready));

   assert_len_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (r.plen != 2'd0));

   assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!out_valid && !in_ready));

   assert_flush_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (st == 2'd0));

   assert_plain_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !r.has_imm) |-> (r.plen == 2'd1 && r.imm32 == '0));

   assert_sext16_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r.plen == 2'd2) |-> (r.has_imm && r.imm32[31:16] == {16{r.imm32[15]}}));

   assert_short_imm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r.plen == 2'd1 && r.has_imm) |->
         (r.imm32[31:4] == '0 || r.imm32[31:4] == '1));

   assert_third_from_ext2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && r.plen == 2'd3) |-> (st == 2'd2 && r.has_imm));
endmodule

bind parcel_decoder parcel_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_rec   (out_rec),
   .st        (st_q)
);

// File: tb/parcel_decoder_test.sv
module parcel_decoder_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush;
   logic        in_valid;
   logic [15:0] in_parcel;
   logic        in_ready;
   logic        out_valid;
   logic [50:0] out_rec;

   int checks = 0;
   int fails  = 0;
   logic [15:0] q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   parcel_decoder #(
      .N_IMM16(3), .N_IMM32(3),
      .IMM16_OPS({8'h83, 8'h93, 8'h95}),
      .IMM32_OPS({8'h84, 8'h94, 8'h95})
   ) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_parcel(in_parcel), .in_ready(in_ready), .out_valid(out_valid), .out_rec(out_rec)
   );

   function automatic int need(input logic [7:0] op);
      if (op == 8'h84 || op == 8'h94 || op == 8'h95) return 3;
      if (op == 8'h83 || op == 8'h93) return 2;
      return 1;
   endfunction

   function automatic logic [50:0] expect_rec(input logic [15:0] p0, input logic [15:0] p1,
                                              input logic [15:0] p2, input int n);
      logic [31:0] imm;
      logic        hi;
      hi  = 1'b1;
      imm = 32'd0;
      if (n == 3) imm = {p2, p1};
      else if (n == 2) imm = {{16{p1[15]}}, p1};
      else if (p0[15:8] == 8'h8E) imm = ~{28'd0, p0[7:4]};
      else if (p0[15:8] == 8'h82 || p0[15:8] == 8'h8A || p0[15:8] == 8'h8C) imm = {28'd0, p0[7:4]};
      else hi = 1'b0;
      return {p0[15:8], p0[7:4], p0[3:0], imm, hi, n[1:0]};
   endfunction

   task automatic step(input logic v, input logic [15:0] p, input logic f);
      logic        ev;
      logic [50:0] er;
      string       tag;
      int          n;
      in_valid = v; in_parcel = p; flush = f;
      #1;
      ev = 1'b0; er = '0; n = 0;
      if (f) tag = "R7";
      else if (v) begin
         q.push_back(p);
         n = need(q[0][15:8]);
         if (q.size() == n) begin
            ev = 1'b1;
            er = expect_rec(q[0], (n > 1) ? q[1] : 16'h0, (n > 2) ? q[2] : 16'h0, n);
         end
         void'(q.pop_back());
      end
      if (f) tag = "R7";
      else if (!ev) tag = "R8";
      else if (n == 3) tag = (er[50:43] == 8'h95) ? "R9" : "R4";
      else if (n == 2) tag = "R3";
      else if (er[50:43] == 8'h8E) tag = "R6";
      else if (er[2]) tag = "R5";
      else tag = "R2";
      checks++;
      if (in_ready !== !f || out_valid !== ev || (ev && out_rec !== er)) begin
         fails++;
         $display("FAIL %s (fields R1/R10): ready=%b valid=%b rec=%h, expected ready=%b valid=%b rec=%h",
                  tag, in_ready, out_valid, out_rec, !f, ev, er);
      end
      @(posedge clk);
      if (f) q.delete();
      else if (v) begin
         q.push_back(p);
         if (q.size() == need(q[0][15:8])) q.delete();
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      logic [7:0]  ops [11];
      ops = '{8'h00, 8'h12, 8'h82, 8'h8A, 8'h8C, 8'h8E, 8'h83, 8'h93, 8'h84, 8'h94, 8'h95};
      rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_parcel = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 16'h0000, 0);                    // R8 reset state
      step(1, 16'h1234, 0);                    // R2, R1
      step(1, 16'h82F3, 0);                    // R5 max short value
      step(1, 16'h8A01, 0);                    // R5
      step(1, 16'h8E57, 0);                    // R6
      step(1, 16'h8E07, 0);                    // R6 zero field
      step(1, 16'h8321, 0); step(1, 16'h8001, 0);   // R3 negative
      step(1, 16'h9312, 0); step(1, 16'h7FFF, 0);   // R3 positive
      step(1, 16'h8445, 0); step(1, 16'h5678, 0); step(1, 16'h1234, 0); // R4
      step(1, 16'h9456, 0); step(0, 16'hDEAD, 0); step(1, 16'hBEEF, 0);
      step(0, 16'h0000, 0); step(1, 16'hCAFE, 0);   // R4, R8 gaps
      step(1, 16'h95AB, 0); step(1, 16'h0001, 0); step(1, 16'h8000, 0); // R9
      step(1, 16'h8311, 0); step(1, 16'h1111, 1); step(1, 16'h8C09, 0); // R7 in EXT1
      step(1, 16'h8422, 0); step(1, 16'h2222, 0); step(0, 16'h0, 1);
      step(1, 16'h8E0F, 0);                    // R7 in EXT2
      step(1, 16'h4321, 1); step(0, 16'h0, 0);      // R7 flush with base parcel
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         logic [15:0] par;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         par  = {lfsr[7:0] ^ lfsr[15:8], lfsr[11:4]};
         if (lfsr[3:1] != 3'd0 && (q.size() == 0)) par[15:8] = ops[lfsr[15:8] % 11];
         step(lfsr[2:0] != 3'd0, par, lfsr[6:2] == 5'd0);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule